// File: doc/BRIEF.md
# Shift-and-Integrate Filter Sequencer

This block sequences a two-dimensional array of per-pixel up/down counters so that the array computes a filtered image by itself. The block does not touch pixel data. It drives five kinds of control: a one-cycle array clear, an integration gate, the count direction, a bank select for arrays whose counters split into two halves, and one-pixel shift commands. Each frame is built from a list of steps. A step is an optional single-cycle shift followed by an integration window that lasts a given number of time-unit ticks.

Four frame recipes are built in. The edge recipe runs one long positive window, then visits the eight neighbours with short negative windows, and then shifts the result back home. The velocity recipe alternates the count direction over a run of short windows, so that only moving objects leave a signature. The stabilise recipe follows a known motion for the first half of the frame and then counts down in place, which removes the static background. The split-bank recipe gives each counter half its own diagonal-difference kernel in four parts. The mode, the period count and the motion direction are sampled once at the start of each frame. At the end of the frame the block raises a readout request and waits for an acknowledge before it clears the array and starts the next frame.

Top module: `shift_integrate_sequencer`

## Requirements
- R1: While reset is high, `arr_clear` is 1 and `integ_en`, `rd_req`, `count_down` and `bank_sel` are 0, and `shift_cmd` is 0 (no shift).
- R2: Every frame begins with `arr_clear` high for exactly one cycle. `mode_sel`, `period_cnt` and `motion_dir` are sampled in that cycle. Mode codes: 0 edge, 1 velocity, 2 stabilise, 3 split-bank. Shift codes on `shift_cmd` and `motion_dir`: 0 none, 1 up, 2 left, 3 down, 4 right.
- R3: In edge mode a frame is one up-count window of 8 ticks, bank 0. Eight down-count windows of 1 tick each follow. Each of them is preceded by one shift, in the order up, left, down, down, right, right, up, up.
- R4: An edge-mode frame ends with a down shift and then a left shift, with no integration after them. The net shift over the whole frame is zero.
- R5: A velocity-mode frame has `period_cnt` windows of 1 tick each, with no shifts. Window k, counted from 1, counts up when k is odd and down when k is even.
- R6: A stabilise-mode frame has `period_cnt` up-count windows of 1 tick, each preceded by one shift in the direction `motion_dir`. These are followed by `period_cnt` down-count windows of 1 tick with no shifts. A `motion_dir` value above 4 means no shift.
- R7: A split-bank frame runs four windows of `period_cnt` ticks each: bank 0 up, then bank 1 up, then bank 0 down, then bank 1 down. Shifts up, left and down come before windows two, three and four, and a final right shift follows the fourth window.
- R8: A shift command lasts exactly one cycle and never coincides with `integ_en`.
- R9: Each integration window keeps `integ_en` high across exactly the programmed number of `tick` pulses. It ends in the cycle after the last of those ticks, and `count_down` stays constant within the window.
- R10: After the last step `rd_req` rises and stays high, with integration off, until `rd_ack`. The cycle after the acknowledge is the clear of the next frame. Changes on the configuration inputs after the frame has started have no effect on that frame.
- R11: A `period_cnt` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-unit pulse |
| mode_sel | input | 2 | Frame recipe, sampled at frame start |
| period_cnt | input | PER_W | Period count or part length, sampled at frame start |
| motion_dir | input | 3 | Known motion direction for stabilise mode |
| rd_ack | input | 1 | Acknowledge of the readout request |
| arr_clear | output | 1 | Clear the counter array |
| integ_en | output | 1 | Integration gate |
| count_down | output | 1 | Count direction, 1 = down |
| bank_sel | output | 1 | Counter bank that integrates |
| shift_cmd | output | 3 | One-cycle shift command |
| rd_req | output | 1 | Frame finished, readout requested |

## Verification
The assertions rely on `tick` being a pulse sampled on the clock. They also rely on `rd_ack` being taken into account only while `rd_req` is high. The bench drives `tick` as a one-cycle pulse every third cycle, so windows end at known edges. It raises `rd_ack` for a single cycle, and only after it has seen the request and held it for several cycles. The bench also rewrites the configuration inputs a few cycles into every frame, to show that the recipe latched at the clear is the one that runs.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    MD_EDGE  = 2'd0,
    MD_VELO  = 2'd1,
    MD_STAB  = 2'd2,
    MD_SPLIT = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SH_NONE  = 3'd0,
    SH_UP    = 3'd1,
    SH_LEFT  = 3'd2,
    SH_DOWN  = 3'd3,
    SH_RIGHT = 3'd4
  } shift_e;

  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_STEP  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_INTEG = 3'd3,
    ST_REQ   = 3'd4
  } phase_e;

  typedef struct packed {
    shift_e dir;
    logic   down;
    logic   bank;
    logic   last;
  } step_ctl_t;

  // Neighbour walk for the edge kernel: visits all eight neighbours.
  function automatic shift_e ring_dir(input logic [2:0] k);
    case (k)
      3'd0:    ring_dir = SH_UP;
      3'd1:    ring_dir = SH_LEFT;
      3'd2:    ring_dir = SH_DOWN;
      3'd3:    ring_dir = SH_DOWN;
      3'd4:    ring_dir = SH_RIGHT;
      3'd5:    ring_dir = SH_RIGHT;
      default: ring_dir = SH_UP;
    endcase
  endfunction

endpackage

// File: rtl/fsq_step_table.sv
module fsq_step_table
  import fsq_pkg::*;
#(
  parameter int PER_W      = 8,
  parameter int HP_LONG    = 8,
  parameter int HP_SHORT   = 1,
  parameter int VEL_TICKS  = 1,
  parameter int STAB_TICKS = 1
) (
  input  mode_e            mode,
  input  logic [PER_W:0]   idx,
  input  logic [PER_W-1:0] periods,
  input  shift_e           motion,
  output step_ctl_t        ctl,
  output logic [PER_W-1:0] ticks
);
  localparam int IDX_W  = PER_W + 1;
  localparam int RING_N = 8;

  logic [IDX_W-1:0] p_ext;
  logic [IDX_W-1:0] p2_ext;
  assign p_ext  = {1'b0, periods};
  assign p2_ext = {periods, 1'b0};

  always_comb begin
    ctl   = '{dir: SH_NONE, down: 1'b0, bank: 1'b0, last: 1'b0};
    ticks = '0;
    case (mode)
      MD_EDGE: begin
        if (idx == '0) begin
          ticks = PER_W'(HP_LONG);
        end else if (idx <= IDX_W'(RING_N)) begin
          ctl.dir  = ring_dir(3'(idx - 1'b1));
          ctl.down = 1'b1;
          ticks    = PER_W'(HP_SHORT);
        end else if (idx == IDX_W'(RING_N + 1)) begin
          ctl.dir = SH_DOWN;
        end else begin
          ctl.dir  = SH_LEFT;
          ctl.last = 1'b1;
        end
      end
      MD_VELO: begin
        ctl.down = idx[0];
        ticks    = PER_W'(VEL_TICKS);
        ctl.last = (idx == p_ext - 1'b1);
      end
      MD_STAB: begin
        if (idx < p_ext) begin
          ctl.dir = motion;
        end else begin
          ctl.down = 1'b1;
        end
        ticks    = PER_W'(STAB_TICKS);
        ctl.last = (idx == p2_ext - 1'b1);
      end
      default: begin
        case (idx[2:0])
          3'd0: ticks = periods;
          3'd1: begin ctl.dir = SH_UP;   ctl.bank = 1'b1; ticks = periods; end
          3'd2: begin ctl.dir = SH_LEFT; ctl.down = 1'b1; ticks = periods; end
          3'd3: begin
            ctl.dir  = SH_DOWN;
            ctl.down = 1'b1;
            ctl.bank = 1'b1;
            ticks    = periods;
          end
          default: begin ctl.dir = SH_RIGHT; ctl.last = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fsq_tick_timer.sv
module fsq_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign done = run && tick && (cnt == target - 1'b1);

  // R9: the window never counts past its programmed length
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    (run && target != '0) |-> (cnt < target));
endmodule

// File: rtl/shift_integrate_sequencer.sv
module shift_integrate_sequencer
  import fsq_pkg::*;
#(
  parameter int PER_W      = 8,
  parameter int HP_LONG    = 8,
  parameter int HP_SHORT   = 1,
  parameter int VEL_TICKS  = 1,
  parameter int STAB_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       mode_sel,
  input  logic [PER_W-1:0] period_cnt,
  input  logic [2:0]       motion_dir,
  input  logic             rd_ack,
  output logic             arr_clear,
  output logic             integ_en,
  output logic             count_down,
  output logic             bank_sel,
  output logic [2:0]       shift_cmd,
  output logic             rd_req
);
  localparam int IDX_W = PER_W + 1;

  phase_e           state;
  logic [IDX_W-1:0] idx;
  mode_e            mode_r;
  logic [PER_W-1:0] per_r;
  shift_e           mot_r;
  step_ctl_t        cur_ctl;
  logic [PER_W-1:0] cur_ticks;

  step_ctl_t        tab_ctl;
  logic [PER_W-1:0] tab_ticks;
  logic             tm_done;

  fsq_step_table #(
    .PER_W(PER_W), .HP_LONG(HP_LONG), .HP_SHORT(HP_SHORT),
    .VEL_TICKS(VEL_TICKS), .STAB_TICKS(STAB_TICKS)
  ) u_table (
    .mode(mode_r), .idx(idx), .periods(per_r), .motion(mot_r),
    .ctl(tab_ctl), .ticks(tab_ticks)
  );

  fsq_tick_timer #(.W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_INTEG), .tick(tick),
    .target(cur_ticks), .done(tm_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      idx       <= '0;
      mode_r    <= MD_EDGE;
      per_r     <= PER_W'(1);
      mot_r     <= SH_NONE;
      cur_ctl   <= '{dir: SH_NONE, down: 1'b0, bank: 1'b0, last: 1'b0};
      cur_ticks <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          mode_r <= mode_e'(mode_sel);
          per_r  <= (period_cnt == '0) ? PER_W'(1) : period_cnt;
          mot_r  <= (motion_dir > 3'd4) ? SH_NONE : shift_e'(motion_dir);
          idx    <= '0;
          state  <= ST_STEP;
        end
        ST_STEP: begin
          cur_ctl   <= tab_ctl;
          cur_ticks <= tab_ticks;
          if (tab_ctl.dir != SH_NONE) state <= ST_SHIFT;
          else if (tab_ticks != '0)   state <= ST_INTEG;
          else if (tab_ctl.last)      state <= ST_REQ;
          else                        idx   <= idx + 1'b1;
        end
        ST_SHIFT: begin
          if (cur_ticks != '0)   state <= ST_INTEG;
          else if (cur_ctl.last) state <= ST_REQ;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_STEP;
          end
        end
        ST_INTEG: begin
          if (tm_done) begin
            if (cur_ctl.last) state <= ST_REQ;
            else begin
              idx   <= idx + 1'b1;
              state <= ST_STEP;
            end
          end
        end
        ST_REQ: begin
          if (rd_ack) state <= ST_CLEAR;
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  assign arr_clear  = (state == ST_CLEAR);
  assign integ_en   = (state == ST_INTEG);
  assign count_down = cur_ctl.down;
  assign bank_sel   = cur_ctl.bank;
  assign shift_cmd  = (state == ST_SHIFT) ? cur_ctl.dir : SH_NONE;
  assign rd_req     = (state == ST_REQ);

  // R2: the clear is a single-cycle pulse
  p_clear_single_r2: assert property (@(posedge clk) disable iff (rst)
    arr_clear |=> !arr_clear);
  // R2: an acknowledged request restarts with a clear
  p_ack_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> arr_clear);
  // R8: shift commands are single-cycle pulses
  p_shift_single_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_cmd != 3'd0) |=> (shift_cmd == 3'd0));
  // R9: a window closes only on a tick
  p_integ_needs_tick_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(integ_en) |-> $past(tick));
  // R9: direction constant inside a window
  p_dir_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (integ_en && $past(integ_en)) |-> $stable(count_down));
  // R10: request holds until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);
  // R10: no integration while readout is pending
  p_no_integ_req_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !integ_en);
endmodule

// File: tb/shift_integrate_sequencer_bench.sv
module shift_integrate_sequencer_bench;
  localparam int PER_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic [1:0]       mode_sel = 2'd0;
  logic [PER_W-1:0] period_cnt = '0;
  logic [2:0]       motion_dir = 3'd0;
  logic             rd_ack = 1'b0;
  logic             arr_clear, integ_en, count_down, bank_sel, rd_req;
  logic [2:0]       shift_cmd;

  shift_integrate_sequencer #(.PER_W(PER_W)) u_shift_integrate_sequencer (
    .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel),
    .period_cnt(period_cnt), .motion_dir(motion_dir), .rd_ack(rd_ack),
    .arr_clear(arr_clear), .integ_en(integ_en), .count_down(count_down),
    .bank_sel(bank_sel), .shift_cmd(shift_cmd), .rd_req(rd_req)
  );

  always #4 clk = ~clk;   // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit finished = 0;

  function automatic int mk(input int kind, input int a, input int b);
    return kind * 65536 + a * 256 + b;
  endfunction

  task automatic push_ev(input int ev, input string tag);
    exp_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  // Expected event list per frame, built from the requirements.
  task automatic push_frame(input int md, input int p, input int mot, input string tag);
    int pe;
    int ring[8] = '{1, 2, 3, 3, 4, 4, 1, 1};
    pe = (p == 0) ? 1 : p;
    push_ev(mk(1, 0, 0), tag);
    case (md)
      0: begin
        push_ev(mk(3, 0, 8), tag);
        for (int i = 0; i < 8; i++) begin
          push_ev(mk(2, ring[i], 0), tag);
          push_ev(mk(3, 2, 1), tag);
        end
        push_ev(mk(2, 3, 0), tag);
        push_ev(mk(2, 2, 0), tag);
      end
      1: for (int k = 0; k < pe; k++) push_ev(mk(3, (k % 2) * 2, 1), tag);
      2: begin
        for (int k = 0; k < pe; k++) begin
          if (mot >= 1 && mot <= 4) push_ev(mk(2, mot, 0), tag);
          push_ev(mk(3, 0, 1), tag);
        end
        for (int k = 0; k < pe; k++) push_ev(mk(3, 2, 1), tag);
      end
      default: begin
        push_ev(mk(3, 0, pe), tag);
        push_ev(mk(2, 1, 0), tag);
        push_ev(mk(3, 1, pe), tag);
        push_ev(mk(2, 2, 0), tag);
        push_ev(mk(3, 2, pe), tag);
        push_ev(mk(2, 3, 0), tag);
        push_ev(mk(3, 3, pe), tag);
        push_ev(mk(2, 4, 0), tag);
      end
    endcase
    push_ev(mk(4, 0, 0), tag);
  endtask

  task automatic chk_event(input int act);
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R2 R10: unexpected event actual %h expected none", act);
    end else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != act) begin
        n_bad++;
        $display("FAIL %s: event actual %h expected %h", t, act, e);
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Tick generator: one-cycle pulse every third cycle.
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1 tick = (ph == 2);
      ph = (ph + 1) % 3;
    end
  end

  // Monitor: turns the outputs into events and pops the scoreboard.
  bit seg_on = 0, seg_down = 0, seg_bank = 0, seg_bad = 0, req_prev = 0;
  int seg_ticks = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (seg_on && !integ_en) begin
        chk_event(mk(3, seg_bad ? 7 : (seg_down * 2 + seg_bank), seg_ticks));
        seg_on = 0;
      end
      if (integ_en) begin
        if (!seg_on) begin
          seg_on = 1; seg_ticks = 0; seg_bad = 0;
          seg_down = count_down; seg_bank = bank_sel;
        end else if (count_down != seg_down || bank_sel != seg_bank) begin
          seg_bad = 1;   // R9 direction stability
        end
        if (tick) seg_ticks++;
      end
      if (arr_clear) chk_event(mk(1, 0, 0));
      if (shift_cmd != 3'd0) begin
        chk_event(mk(2, int'(shift_cmd), 0));
        chk(!integ_en, "R8 shift with integration", int'(integ_en), 0);
      end
      if (rd_req && !req_prev) chk_event(mk(4, 0, 0));
      req_prev = rd_req;
    end
  end

  task automatic set_cfg(input int md, input int p, input int mot);
    mode_sel = 2'(md); period_cnt = PER_W'(p); motion_dir = 3'(mot);
  endtask

  // Wait for the request, hold it, then acknowledge into the next frame.
  task automatic finish_frame(input int md, input int p, input int mot, input string tag);
    while (!rd_req) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rd_req && !integ_en, "R10 request held", int'(rd_req), 1);
    end
    @(posedge clk);
    #1;
    set_cfg(md, p, mot);
    push_frame(md, p, mot, tag);
    rd_ack = 1'b1;
    @(posedge clk);
    #1 rd_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 set_cfg(3 - md, p + 5, 2);   // R10: mid-frame changes are ignored
  endtask

  initial begin
    set_cfg(0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(arr_clear && !integ_en && !rd_req && shift_cmd == 3'd0 && !count_down && !bank_sel,
        "R1 reset state", int'(arr_clear), 1);
    push_frame(0, 0, 0, "R2 R3 R4 R9");
    @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #1 set_cfg(1, 9, 3);
    finish_frame(1, 6, 0, "R5 R9");
    finish_frame(2, 3, 4, "R6");
    finish_frame(3, 2, 0, "R7 R9");
    finish_frame(1, 0, 0, "R11");
    finish_frame(2, 2, 6, "R6 R11");
    finish_frame(1, 40, 0, "R5");
    finish_frame(0, 3, 1, "R3 R4 R10");
    while (!rd_req) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all events seen", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R10: watchdog expired actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule